// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees a hung I2C bus before a host TWI master is switched on. When a request arrives it holds the master's enable bit in a local register, turns the master off and takes over both bus lines. Each line is driven like an open-drain output. The data value on each line is tied to zero, so a line is pulled low by asserting its output enable and released by removing that enable. The block never drives a line high.

Each recovery attempt runs in a fixed order. First it releases both lines. Next it forms a START by pulling SDA low while SCL is still free. It then pulls both lines low. It forms a STOP by releasing SCL first and SDA second. Finally it waits one millisecond and reads a two-bit bus-state input. The attempt repeats while that input reports busy, up to a retry limit. An optional full-clear mode first clocks SCL up to a fixed number of times, so that a slave holding SDA low can finish its byte. At the end the block restores the master enable only if it was set before the recovery began.

All delays are whole multiples of a microsecond unit, and that unit is set by a clock-cycles-per-microsecond parameter.

Top module: `i2c_bus_clear`

## Requirements
- R1: The pin data outputs `sda_out_o` and `scl_out_o` are always 0. A line is pulled low only by asserting its output enable. Both output enables are 0 whenever `busy_o` is 0.
- R2: On an accepted request the current master enable is saved and `mst_en_o` goes to 0 for the whole run. A write (`mst_en_we_i`) is applied to the enable only while idle and is ignored while busy.
- R3: Each attempt has three phases, each lasting one microsecond unit (CYC_PER_US cycles). First both enables are 0. Then only the SDA enable is 1 (START). Then both enables are 1.
- R4: The STOP releases SCL first. For one unit only the SDA enable is 1. Then SDA is released and both enables stay 0 for MS_US units before the bus state is read.
- R5: Another attempt starts only when `bus_state_i` equals 2'b11 (busy) at the end of the wait. Any other code (2'b00, 2'b01, 2'b10) ends the run successfully.
- R6: At most MAX_TRIES attempts are made. If the bus still reads busy after the last one, `timeout_o` is set, the run ends and `mst_en_o` stays 0.
- R7: On a successful end, `mst_en_o` returns to 1 only if the saved enable was 1. Otherwise it stays 0.
- R8: In full-clear mode (`full_mode_i` = 1 at the request) the block checks SDA after the release phase. While SDA is sampled low and fewer than MAX_PULSES pulses have been issued in this attempt, it issues an SCL pulse: one unit with only the SCL enable set, then one unit with no enable set, then SDA is checked again. When SDA is high or the pulse limit is reached, it proceeds to the START. In normal mode no pulses are issued.
- R9: `done_o` is high for exactly one cycle at the end of each run. `timeout_o` is cleared when a request is accepted and otherwise holds its value until the next request.
- R10: A request that arrives while busy has no effect on the line sequence.
- R11: The one-unit phase lasts CYC_PER_US cycles. The final wait lasts MS_US times CYC_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, sampled while idle |
| full_mode_i | input | 1 | Selects full-clear mode with SCL pulses; sampled with the request |
| mst_en_we_i | input | 1 | Write strobe for the master enable, idle only |
| mst_en_wd_i | input | 1 | Value written to the master enable |
| bus_state_i | input | 2 | Bus state from the master; 2'b11 means busy |
| sda_i | input | 1 | SDA line sample (asynchronous) |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | Retry limit was reached in the last run |
| mst_en_o | output | 1 | Enable to the TWI master |
| sda_oe_o | output | 1 | SDA output enable (1 pulls the line low) |
| scl_oe_o | output | 1 | SCL output enable (1 pulls the line low) |
| sda_out_o | output | 1 | SDA pin data value, always 0 |
| scl_out_o | output | 1 | SCL pin data value, always 0 |

## Verification
The hardest case to reach is a slave that keeps SDA low across attempt boundaries. In that case the per-attempt pulse count of full-clear mode must restart and must stop at its limit. To produce it, the bench models the slave as a counter. The counter releases SDA after a chosen number of SCL rising edges, and the STOP's SCL release also counts as one of those edges. Hold lengths below, at and above the pulse limit are combined with bus-busy reports at the retry limit and around it. From each combination the bench predicts every run of output-enable values and its length in cycles.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REL,
    ST_PLO,
    ST_PHI,
    ST_START,
    ST_LOW,
    ST_STOPC,
    ST_WAIT
  } bc_state_e;

  localparam logic [1:0] BUS_BUSY = 2'b11;
endpackage

// File: rtl/i2c_bc_sync.sv
module i2c_bc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          r_q <= {STAGES{RST_VAL}};
        end else begin
          r_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) r_q[i] <= r_q[i-1];
        end
      end
      assign q_o = r_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_bc_timer.sv
module i2c_bc_timer #(
  parameter int MAX_LOAD = 1000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ld_i,
  input  logic [$clog2(MAX_LOAD+1)-1:0] val_i,
  output logic                          zero_o
);
  localparam int W = $clog2(MAX_LOAD + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (ld_i)           cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R11: the count never rises on its own
  assert_tmr_monotonic_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/i2c_bc_ctr.sv
module i2c_bc_ctr #(
  parameter int MAX = 255
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     inc_i,
  output logic [$clog2(MAX+1)-1:0] q_o
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (inc_i)  q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

  // R6 / R8: attempt and pulse counts stay inside their limit
  assert_ctr_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q <= W'(MAX));
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int CYC_PER_US  = 250,
  parameter int MS_US       = 1000,
  parameter int MAX_TRIES   = 255,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       full_mode_i,
  input  logic       mst_en_we_i,
  input  logic       mst_en_wd_i,
  input  logic [1:0] bus_state_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic       mst_en_o,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       sda_out_o,
  output logic       scl_out_o
);
  localparam int MS_CYC = CYC_PER_US * MS_US;
  localparam int TMW    = $clog2(MS_CYC + 1);
  localparam int TRW    = $clog2(MAX_TRIES + 1);
  localparam int PLW    = $clog2(MAX_PULSES + 1);
  localparam logic [TMW-1:0] US_LD = TMW'(CYC_PER_US - 1);
  localparam logic [TMW-1:0] MS_LD = TMW'(MS_CYC - 1);

  bc_state_e      st_q, st_d;
  logic           tmr_ld, tmr_zero;
  logic [TMW-1:0] tmr_val;
  logic           try_clr, try_inc, pls_clr, pls_inc;
  logic [TRW-1:0] try_q;
  logic [PLW-1:0] pls_q;
  logic           finish, give_up;
  logic           sda_s;
  logic           saved_q, full_q, mst_en_q, done_q, tmo_q;
  logic           sda_oe_q, scl_oe_q;

  i2c_bc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  i2c_bc_timer #(.MAX_LOAD(MS_CYC)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .ld_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  i2c_bc_ctr #(.MAX(MAX_TRIES)) u_try (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(try_clr), .inc_i(try_inc), .q_o(try_q)
  );

  i2c_bc_ctr #(.MAX(MAX_PULSES)) u_pls (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(pls_clr), .inc_i(pls_inc), .q_o(pls_q)
  );

  // pulse while SDA is held low and the pulse budget remains
  logic want_pulse;
  assign want_pulse = full_q && !sda_s && (pls_q < PLW'(MAX_PULSES));

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    try_clr = 1'b0;
    try_inc = 1'b0;
    pls_clr = 1'b0;
    pls_inc = 1'b0;
    finish  = 1'b0;
    give_up = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_REL; tmr_ld = 1'b1; tmr_val = US_LD;
        try_clr = 1'b1; pls_clr = 1'b1;
      end
      ST_REL, ST_PHI: if (tmr_zero) begin
        tmr_ld = 1'b1; tmr_val = US_LD;
        if (want_pulse) begin
          st_d = ST_PLO; pls_inc = 1'b1;
        end else begin
          st_d = ST_START;
        end
      end
      ST_PLO:   if (tmr_zero) begin st_d = ST_PHI;   tmr_ld = 1'b1; tmr_val = US_LD; end
      ST_START: if (tmr_zero) begin st_d = ST_LOW;   tmr_ld = 1'b1; tmr_val = US_LD; end
      ST_LOW:   if (tmr_zero) begin st_d = ST_STOPC; tmr_ld = 1'b1; tmr_val = US_LD; end
      ST_STOPC: if (tmr_zero) begin st_d = ST_WAIT;  tmr_ld = 1'b1; tmr_val = MS_LD; end
      ST_WAIT: if (tmr_zero) begin
        try_inc = 1'b1;
        if (bus_state_i == BUS_BUSY) begin
          if (try_q == TRW'(MAX_TRIES - 1)) begin
            st_d = ST_IDLE; give_up = 1'b1;
          end else begin
            st_d = ST_REL; tmr_ld = 1'b1; tmr_val = US_LD; pls_clr = 1'b1;
          end
        end else begin
          st_d = ST_IDLE; finish = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      saved_q  <= 1'b0;
      full_q   <= 1'b0;
      mst_en_q <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      done_q   <= finish | give_up;
      sda_oe_q <= (st_d == ST_START) || (st_d == ST_LOW) || (st_d == ST_STOPC);
      scl_oe_q <= (st_d == ST_PLO) || (st_d == ST_LOW);
      if (st_q == ST_IDLE && start_i) begin
        saved_q  <= mst_en_q;
        mst_en_q <= 1'b0;
        full_q   <= full_mode_i;
        tmo_q    <= 1'b0;
      end else if (st_q == ST_IDLE && mst_en_we_i) begin
        mst_en_q <= mst_en_wd_i;
      end
      if (give_up) tmo_q <= 1'b1;
      if (finish && saved_q) mst_en_q <= 1'b1;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign mst_en_o  = mst_en_q;
  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = scl_oe_q;
  assign sda_out_o = 1'b0;
  assign scl_out_o = 1'b0;

  assert_oe_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sda_oe_o && !scl_oe_o));

  assert_mst_off_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mst_en_o);

  assert_start_form_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_oe_o);

  assert_stop_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o);

  assert_tmo_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);

  assert_pulse_no_sda_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) && !sda_oe_o |-> full_q);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/i2c_bus_clear_bench.sv
module i2c_bus_clear_bench;
  localparam int U  = 4;
  localparam int MSU = 3;
  localparam int MT = 3;
  localparam int MP = 9;
  localparam int MS = U * MSU;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, full_mode_i = 1'b0;
  logic       mst_en_we_i = 1'b0, mst_en_wd_i = 1'b0;
  logic [1:0] bus_state_i;
  logic       sda_i;
  logic       busy_o, done_o, timeout_o, mst_en_o;
  logic       sda_oe_o, scl_oe_o, sda_out_o, scl_out_o;

  always #2 clk_i = ~clk_i;

  i2c_bus_clear #(.CYC_PER_US(U), .MS_US(MSU), .MAX_TRIES(MT),
                  .MAX_PULSES(MP), .SYNC_STAGES(2)) u_i2c_bus_clear (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .full_mode_i(full_mode_i),
    .mst_en_we_i(mst_en_we_i), .mst_en_wd_i(mst_en_wd_i), .bus_state_i(bus_state_i),
    .sda_i(sda_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .mst_en_o(mst_en_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o),
    .sda_out_o(sda_out_o), .scl_out_o(scl_out_o)
  );

  int errors = 0, checks = 0;
  int cyc = 0;

  // bus and slave model
  int nbusy = 0, starts = 0, hold_cnt = 0;
  logic [1:0] idle_code = 2'b00;
  assign bus_state_i = (starts <= nbusy) ? 2'b11 : idle_code;
  assign sda_i = !sda_oe_o && (hold_cnt == 0);

  // expected enable runs, pair = {sda_oe, scl_oe}
  logic [1:0] exp_pair [0:127];
  int         exp_len  [0:127];
  int         exp_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] p, input int len);
    if (exp_n > 0 && exp_pair[exp_n-1] == p) exp_len[exp_n-1] += len;
    else begin
      exp_pair[exp_n] = p;
      exp_len[exp_n]  = len;
      exp_n++;
    end
  endtask

  task automatic build(input bit full, input int k, input int nb);
    int att, rem, p;
    exp_n = 0;
    att = (nb >= MT) ? MT : nb + 1;
    rem = k;
    for (int a = 0; a < att; a++) begin
      push(2'b00, U);
      p = 0;
      if (full) begin
        p = (rem > MP) ? MP : rem;
        rem -= p;
      end
      for (int i = 0; i < p; i++) begin
        push(2'b01, U);
        push(2'b00, U);
      end
      if (rem > 0) rem--;  // STOP's SCL release also clocks the slave
      push(2'b10, U);
      push(2'b11, U);
      push(2'b10, U);
      push(2'b00, MS);
    end
  endtask

  // monitor
  bit mon_en = 0, in_run = 0, done_seen = 0;
  logic [1:0] cur;
  int run_len = 0, seg_idx = 0, dw = 0;
  int out_bad = 0, en_bad = 0;
  logic prev_sda = 0, prev_scl = 0;

  task automatic close_seg();
    if (seg_idx < exp_n) begin
      chk(cur == exp_pair[seg_idx], "R3/R4/R8/R10 enable pair", int'(cur), int'(exp_pair[seg_idx]));
      chk(run_len == exp_len[seg_idx], "R11/R3/R4 phase length", run_len, exp_len[seg_idx]);
    end else begin
      chk(1'b0, "R5/R6 extra phase", seg_idx, exp_n);
    end
    seg_idx++;
  endtask

  always @(negedge clk_i) begin
    if (sda_out_o || scl_out_o) out_bad++;
    if (busy_o && mst_en_o) en_bad++;
    if (!prev_sda && sda_oe_o && !scl_oe_o) starts++;
    if (prev_scl && !scl_oe_o && hold_cnt > 0) hold_cnt--;
    prev_sda = sda_oe_o;
    prev_scl = scl_oe_o;
    if (mon_en) begin
      if (busy_o) begin
        if (!in_run) begin in_run = 1; cur = {sda_oe_o, scl_oe_o}; run_len = 1; end
        else if ({sda_oe_o, scl_oe_o} == cur) run_len++;
        else begin close_seg(); cur = {sda_oe_o, scl_oe_o}; run_len = 1; end
      end else if (in_run) begin
        close_seg();
        in_run = 0;
      end
      if (done_o) begin dw++; done_seen = 1; end
      else if (dw > 0) begin
        chk(dw == 1, "R9 done width", dw, 1);
        dw = 0;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input bit full, input int k, input int nb, input bit en, input logic [1:0] ic);
    bit exp_tmo;
    int w;
    // idle write of the master enable
    @(negedge clk_i); mst_en_we_i = 1; mst_en_wd_i = en;
    @(negedge clk_i); mst_en_we_i = 0;
    chk(mst_en_o == en, "R2 idle enable write", mst_en_o, en);
    build(full, k, nb);
    exp_tmo = (nb >= MT);
    nbusy = nb; idle_code = ic; starts = 0; hold_cnt = k;
    seg_idx = 0; done_seen = 0; mon_en = 1;
    start_i = 1; full_mode_i = full;
    @(negedge clk_i);
    start_i = 0; full_mode_i = ~full;
    chk(busy_o == 1, "R2 run starts", busy_o, 1);
    chk(timeout_o == 0, "R9 timeout cleared at request", timeout_o, 0);
    chk(mst_en_o == 0, "R2 master off", mst_en_o, 0);
    repeat (12) @(negedge clk_i);
    start_i = 1; mst_en_we_i = 1; mst_en_wd_i = ~en;  // both must be ignored
    @(negedge clk_i);
    start_i = 0; mst_en_we_i = 0;
    w = 0;
    while (!done_seen && w < 3000) begin @(negedge clk_i); w++; end
    chk(done_seen, "R9 done reached", done_seen, 1);
    repeat (6) @(negedge clk_i);
    mon_en = 0;
    chk(seg_idx == exp_n, "R5/R6 phase count", seg_idx, exp_n);
    chk(timeout_o == exp_tmo, "R6/R9 timeout held", timeout_o, exp_tmo);
    chk(mst_en_o == (en && !exp_tmo), "R7/R6/R2 master restore", mst_en_o, en && !exp_tmo);
    chk(!busy_o && !sda_oe_o && !scl_oe_o, "R1 idle enables", {busy_o, sda_oe_o, scl_oe_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !timeout_o && !mst_en_o && !sda_oe_o && !scl_oe_o,
        "R1 reset state", {busy_o, done_o, timeout_o, mst_en_o, sda_oe_o, scl_oe_o}, 0);
    rst_ni = 1;
    for (int f = 0; f < 2; f++) begin
      for (int nb = 0; nb <= MT + 1; nb++) begin
        for (int ki = 0; ki < 4; ki++) begin
          for (int e = 0; e < 2; e++) begin
            int kk;
            kk = (ki == 0) ? 0 : (ki == 1) ? 3 : (ki == 2) ? MP : MP + 3;
            run(f[0], kk, nb, e[0], 2'(ki % 3));  // R5 non-busy codes 00/01/10
          end
        end
      end
    end
    chk(out_bad == 0, "R1 pin data zero", out_bad, 0);
    chk(en_bad == 0, "R2 master off while busy", en_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule